// File: doc/BRIEF.md
# Double-Buffered DMA Channel

This block is one DMA channel that moves data between memory and a peripheral FIFO. It works through two buffer descriptors in ping-pong order. Each descriptor holds a start address and a transfer count. When the active descriptor runs out, the channel flags it done, drops its enable, pulses an interrupt and moves to the other descriptor. Software can refill a finished descriptor while the other one is being transferred, so a stream runs without gaps.

Control goes through a 32-bit register port in a 256-byte window. The mode word has two write aliases: one address sets the bits written as one, and another address clears the bits written as one. Reading the first address returns the current mode. A run bit starts the channel. A read-only halt bit confirms that the channel has stopped, and a read-only bit shows which descriptor is active. One beat is a read followed by a write on a simple request/acknowledge memory port. The direction bit decides whether the FIFO address is the source or the destination. Counts are kept in beats of the selected device width, so the bytes remaining are the count shifted left by the width code.

Top module: `dma_pp_chan`

## Requirements
- R1: After reset the mode word reads 0x0000_0040: only the halt bit (bit 6) is set. The interrupt and the memory request are low.
- R2: A write to offset 0x00 sets every writable mode bit written as one and leaves the others unchanged. The writable bits are 0, 1, 2, 3, 5, 7, 8, 11, 12, 13, 15 and 19:16.
- R3: A write to offset 0x04 clears every writable mode bit written as one.
- R4: Bit 4 (active descriptor) and bit 6 (halt) ignore writes to either alias. The other descriptor registers read back as written: FIFO address at 0x08, start 0/1 at 0x0C/0x14, and count 0/1 at 0x10/0x18. A count register returns bits 19:0 (count in 15:0, upper address in 19:16) and reads zero above bit 19.
- R5: Each beat makes two accesses. With direction (bit 12) at 0, it reads the buffer address and then writes that data to the FIFO address. With direction at 1, it reads the FIFO address and then writes to the buffer address. The buffer address is {count[19:16], start[27:0]}. After each beat the start advances by 1, 2 or 4 for width code (bits 8:7) 0, 1 or 2, and the count drops by one.
- R6: When the active count is zero with run (bit 3) and that descriptor's enable set (bit 0 for 0, bit 2 for 1), the descriptor's done bit sets (bit 1 for 0, bit 5 for 1). In the same step its enable clears, the active bit toggles and the interrupt pulses for one cycle.
- R7: If the other descriptor is enabled, transfer continues on it with no software action. If it is not enabled, halt reads one and no further requests are made.
- R8: Clearing run mid-transfer lets the current beat finish both of its accesses. Halt then reads one, no further requests are made and no interrupt is raised.
- R9: Setting run again while the active descriptor is enabled drops halt and resumes the transfer where it stopped.
- R10: A done bit is cleared by writing one to it at offset 0x04.
- R11: The active descriptor's count register holds the beats still to move, so after a stop it equals the programmed count minus the finished beats.
- R12: With the byte-order bit (13) set, the data of a 32-bit beat (width code 2) has its four bytes reversed. A 16-bit beat (code 1) has its two low bytes swapped and its upper half zeroed.
- R13: A memory request, with its address and write flag, stays stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset within the window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted and completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | One-cycle pulse per finished descriptor |

## Verification
The bench builds the channel with its default parameters: a 16-bit count, four upper address bits, an 8-bit register offset and a two-stage reset synchroniser. Because software programs the counts, counts of one to forty beats are enough to reach the zero-count descriptor switch, back-to-back ping-pong, a stop in the middle of a buffer and its resumption, and all three widths in both directions. The memory model adds random acknowledge delays, so requests are held over several cycles.

// File: rtl/dma_pp_pkg.sv
`timescale 1ns/1ps
package dma_pp_pkg;

  localparam int DATA_W = 32;

  // register offsets inside the channel window
  localparam logic [7:0] OFF_SET  = 8'h00;
  localparam logic [7:0] OFF_CLR  = 8'h04;
  localparam logic [7:0] OFF_FIFO = 8'h08;
  localparam logic [7:0] OFF_S0   = 8'h0C;
  localparam logic [7:0] OFF_C0   = 8'h10;
  localparam logic [7:0] OFF_S1   = 8'h14;
  localparam logic [7:0] OFF_C1   = 8'h18;

  // mode word bit positions
  localparam int B_EN0  = 0;
  localparam int B_DON0 = 1;
  localparam int B_EN1  = 2;
  localparam int B_RUN  = 3;
  localparam int B_ACT  = 4;
  localparam int B_DON1 = 5;
  localparam int B_HALT = 6;
  localparam int B_WID  = 7;   // two bits, 8:7
  localparam int B_DIR  = 12;
  localparam int B_SWAP = 13;

  localparam logic [DATA_W-1:0] MODE_WMASK = 32'h000F_B9AF;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} eng_st_e;

  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] d,
                                                  input logic [1:0] w);
    logic [DATA_W-1:0] r;
    case (w)
      2'd0:    r = d;
      2'd1:    r = {16'h0000, d[7:0], d[15:8]};
      default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
    return r;
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [1:0] w);
    logic [2:0] r;
    case (w)
      2'd0:    r = 3'd1;
      2'd1:    r = 3'd2;
      default: r = 3'd4;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_pp_rst_sync.sv
`timescale 1ns/1ps
module dma_pp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dma_pp_regs.sv
`timescale 1ns/1ps
module dma_pp_regs
  import dma_pp_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int CNT_W  = 16,
  parameter int HI_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [REG_AW-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  input  logic                             done_evt_i,
  input  logic                             beat_evt_i,
  input  logic                             evt_buf_i,
  input  logic [2:0]                       step_i,
  input  logic                             act_i,
  input  logic                             halt_i,
  output logic                             go_o,
  output logic [1:0]                       en_o,
  output logic [1:0]                       width_o,
  output logic                             dir_o,
  output logic                             swap_o,
  output logic [DATA_W-1:0]                fifo_o,
  output logic [1:0][DATA_W-HI_W-1:0]      start_o,
  output logic [1:0][CNT_W-1:0]            cnt_o,
  output logic [1:0][HI_W-1:0]             hi_o
);
  localparam int LOW_W  = DATA_W - HI_W;
  localparam int CREG_W = CNT_W + HI_W;
  localparam logic [REG_AW-1:0] A_SET  = REG_AW'(OFF_SET);
  localparam logic [REG_AW-1:0] A_CLR  = REG_AW'(OFF_CLR);
  localparam logic [REG_AW-1:0] A_FIFO = REG_AW'(OFF_FIFO);
  localparam logic [REG_AW-1:0] A_S0   = REG_AW'(OFF_S0);
  localparam logic [REG_AW-1:0] A_C0   = REG_AW'(OFF_C0);
  localparam logic [REG_AW-1:0] A_S1   = REG_AW'(OFF_S1);
  localparam logic [REG_AW-1:0] A_C1   = REG_AW'(OFF_C1);

  // ---------------- mode word ----------------
  logic [DATA_W-1:0] mode_q, mode_d;
  logic              mode_en;

  always_comb begin
    mode_d = mode_q;
    if (wr_i && addr_i == A_SET)      mode_d = mode_q | (wdata_i & MODE_WMASK);
    else if (wr_i && addr_i == A_CLR) mode_d = mode_q & ~(wdata_i & MODE_WMASK);
    // a finishing descriptor overrides a same-cycle software write
    if (done_evt_i) begin
      if (evt_buf_i) begin
        mode_d[B_DON1] = 1'b1;
        mode_d[B_EN1]  = 1'b0;
      end else begin
        mode_d[B_DON0] = 1'b1;
        mode_d[B_EN0]  = 1'b0;
      end
    end
    mode_en = done_evt_i | (wr_i && (addr_i == A_SET || addr_i == A_CLR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  // ---------------- FIFO address ----------------
  logic [DATA_W-1:0] fifo_q;
  logic              fifo_en;

  assign fifo_en = wr_i && (addr_i == A_FIFO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fifo_q <= '0;
    else if (fifo_en) fifo_q <= wdata_i;
  end

  // ---------------- descriptors ----------------
  logic [1:0][DATA_W-1:0] start_full;
  logic [1:0][CREG_W-1:0] creg_full;

  for (genvar b = 0; b < 2; b++) begin : g_desc
    localparam logic [REG_AW-1:0] A_ST = (b == 0) ? A_S0 : A_S1;
    localparam logic [REG_AW-1:0] A_CN = (b == 0) ? A_C0 : A_C1;

    logic [DATA_W-1:0] s_q, s_d;
    logic [CNT_W-1:0]  c_q, c_d;
    logic [HI_W-1:0]   h_q, h_d;
    logic              sw_s, sw_c, hw_b;

    always_comb begin
      sw_s = wr_i && (addr_i == A_ST);
      sw_c = wr_i && (addr_i == A_CN);
      hw_b = beat_evt_i && (evt_buf_i == 1'(b));
      s_d  = sw_s ? wdata_i : s_q + DATA_W'(step_i);
      c_d  = sw_c ? wdata_i[CNT_W-1:0] : c_q - 1'b1;
      h_d  = sw_c ? wdata_i[CREG_W-1:CNT_W] : h_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           s_q <= '0;
      else if (sw_s | hw_b) s_q <= s_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        h_q <= '0;
      end else if (sw_c | hw_b) begin
        c_q <= c_d;
        h_q <= h_d;
      end
    end

    assign start_full[b] = s_q;
    assign creg_full[b]  = {h_q, c_q};
    assign start_o[b]    = s_q[LOW_W-1:0];
    assign cnt_o[b]      = c_q;
    assign hi_o[b]       = h_q;
  end

  // ---------------- read mux ----------------
  always_comb begin
    case (addr_i)
      A_SET: begin
        rdata_o         = mode_q;
        rdata_o[B_ACT]  = act_i;
        rdata_o[B_HALT] = halt_i;
      end
      A_FIFO:  rdata_o = fifo_q;
      A_S0:    rdata_o = start_full[0];
      A_C0:    rdata_o = DATA_W'(creg_full[0]);
      A_S1:    rdata_o = start_full[1];
      A_C1:    rdata_o = DATA_W'(creg_full[1]);
      default: rdata_o = '0;
    endcase
  end

  assign go_o    = mode_q[B_RUN];
  assign en_o    = {mode_q[B_EN1], mode_q[B_EN0]};
  assign width_o = mode_q[B_WID+1:B_WID];
  assign dir_o   = mode_q[B_DIR];
  assign swap_o  = mode_q[B_SWAP];
  assign fifo_o  = fifo_q;
endmodule

// File: rtl/dma_pp_engine.sv
`timescale 1ns/1ps
module dma_pp_engine
  import dma_pp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int HI_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go_i,
  input  logic [1:0]                  en_i,
  input  logic [1:0]                  width_i,
  input  logic                        dir_i,
  input  logic                        swap_i,
  input  logic [DATA_W-1:0]           fifo_i,
  input  logic [1:0][DATA_W-HI_W-1:0] start_i,
  input  logic [1:0][CNT_W-1:0]       cnt_i,
  input  logic [1:0][HI_W-1:0]        hi_i,
  input  logic                        mem_ack_i,
  input  logic [DATA_W-1:0]           mem_rdata_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [DATA_W-1:0]           mem_addr_o,
  output logic [1:0]                  mem_size_o,
  output logic [DATA_W-1:0]           mem_wdata_o,
  output logic                        beat_evt_o,
  output logic                        done_evt_o,
  output logic                        evt_buf_o,
  output logic [2:0]                  step_o,
  output logic                        act_o,
  output logic                        halt_o,
  output logic                        irq_o
);
  eng_st_e           st_q, st_d;
  logic              act_q, act_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              irq_q;
  logic              run, cnt_zero;
  logic [DATA_W-1:0] buf_addr;

  assign run      = go_i & en_i[act_q];
  assign cnt_zero = (cnt_i[act_q] == '0);
  assign buf_addr = {hi_i[act_q], start_i[act_q]};

  always_comb begin
    st_d       = st_q;
    act_d      = act_q;
    data_d     = data_q;
    data_en    = 1'b0;
    done_evt_o = 1'b0;
    beat_evt_o = 1'b0;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = '0;
    case (st_q)
      ST_IDLE: begin
        if (run) begin
          if (cnt_zero) begin
            done_evt_o = 1'b1;
            act_d      = ~act_q;
          end else begin
            st_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dir_i ? fifo_i : buf_addr;
        if (mem_ack_i) begin
          data_d  = swap_i ? lane_swap(mem_rdata_i, width_i) : mem_rdata_i;
          data_en = 1'b1;
          st_d    = ST_WR;
        end
      end
      ST_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dir_i ? buf_addr : fifo_i;
        if (mem_ack_i) begin
          beat_evt_o = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      act_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      irq_q <= done_evt_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign halt_o      = (st_q == ST_IDLE) & ~run;
  assign evt_buf_o   = act_q;
  assign act_o       = act_q;
  assign step_o      = beat_bytes(width_i);
  assign mem_size_o  = width_i;
  assign mem_wdata_o = data_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/dma_pp_chan.sv
`timescale 1ns/1ps
module dma_pp_chan
  import dma_pp_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int CNT_W       = 16,
  parameter int HI_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);
  localparam int LOW_W = DATA_W - HI_W;

  logic                   rst_sync_n;
  logic                   go_w, dir_w, swap_w, act_w, halt_w;
  logic [1:0]             en_w, width_w;
  logic [DATA_W-1:0]      fifo_w;
  logic [1:0][LOW_W-1:0]  start_w;
  logic [1:0][CNT_W-1:0]  cnt_w;
  logic [1:0][HI_W-1:0]   hi_w;
  logic                   beat_w, done_w, evt_buf_w;
  logic [2:0]             step_w;

  dma_pp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  dma_pp_regs #(.REG_AW(REG_AW), .CNT_W(CNT_W), .HI_W(HI_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .done_evt_i (done_w),
    .beat_evt_i (beat_w),
    .evt_buf_i  (evt_buf_w),
    .step_i     (step_w),
    .act_i      (act_w),
    .halt_i     (halt_w),
    .go_o       (go_w),
    .en_o       (en_w),
    .width_o    (width_w),
    .dir_o      (dir_w),
    .swap_o     (swap_w),
    .fifo_o     (fifo_w),
    .start_o    (start_w),
    .cnt_o      (cnt_w),
    .hi_o       (hi_w)
  );

  dma_pp_engine #(.CNT_W(CNT_W), .HI_W(HI_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .go_i        (go_w),
    .en_i        (en_w),
    .width_i     (width_w),
    .dir_i       (dir_w),
    .swap_i      (swap_w),
    .fifo_i      (fifo_w),
    .start_i     (start_w),
    .cnt_i       (cnt_w),
    .hi_i        (hi_w),
    .mem_ack_i   (mem_ack),
    .mem_rdata_i (mem_rdata),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_size_o  (mem_size),
    .mem_wdata_o (mem_wdata),
    .beat_evt_o  (beat_w),
    .done_evt_o  (done_w),
    .evt_buf_o   (evt_buf_w),
    .step_o      (step_w),
    .act_o       (act_w),
    .halt_o      (halt_w),
    .irq_o       (irq)
  );
endmodule

// File: rtl/dma_pp_chan_chk.sv
`timescale 1ns/1ps
module dma_pp_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halt,
  input logic        go,
  input logic        act,
  input logic [1:0]  en,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        irq
);
  // a halted channel makes no memory request
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_req);

  // after the write of a beat completes with run low, the channel is halted
  assert_stop_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !go) |=> (halt || go));

  // a pending request keeps its address and direction
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // every interrupt pulse coincides with a descriptor switch
  assert_irq_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (act != $past(act)));

  // the descriptor just left has its enable dropped
  assert_left_en0_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !$past(act)) |-> !en[0]);

  assert_left_en1_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && $past(act)) |-> !en[1]);
endmodule

bind dma_pp_chan dma_pp_chan_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .halt     (halt_w),
  .go       (go_w),
  .act      (act_w),
  .en       (en_w),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .irq      (irq)
);

// File: tb/tb_dma_pp_chan.sv
`timescale 1ns/1ps
module tb_dma_pp_chan;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int log_n = 0;
  bit finished = 0;
  logic        log_we   [256];
  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];

  localparam logic [31:0] WMASK = 32'h000F_B9AF;

  dma_pp_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic int step_of(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int target);
    for (int i = 0; i < 3000 && irq_cnt < target; i++) @(negedge clk);
  endtask

  task automatic wait_halt();
    logic [31:0] m;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h00, m);
      if (m[6]) break;
    end
  endtask

  task automatic wait_log(input int target);
    for (int i = 0; i < 3000 && log_n < target; i++) @(negedge clk);
  endtask

  // memory responder with random acknowledge delay; checks R13 while waiting
  initial begin
    int wait_n;
    bit held;
    logic [31:0] h_addr;
    logic h_we;
    mem_ack = 1'b0; mem_rdata = '0; wait_n = 0; held = 0;
    h_addr = '0; h_we = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_n = $urandom % 3;
      end else if (mem_req) begin
        if (!held) begin
          held = 1; h_addr = mem_addr; h_we = mem_we;
        end else begin
          check("R13 held address", mem_addr, h_addr);
          check("R13 held write flag", 32'(mem_we), 32'(h_we));
        end
        if (wait_n == 0) begin
          mem_ack = 1'b1;
          held = 0;
          if (log_n < 256) begin
            log_we[log_n]   = mem_we;
            log_addr[log_n] = mem_addr;
            if (mem_we) log_data[log_n] = mem_wdata;
            else begin
              mem_rdata = mem_val(mem_addr);
              log_data[log_n] = mem_rdata;
            end
            log_n++;
          end
        end else begin
          wait_n--;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq) irq_cnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R7 watchdog: actual still running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] m, d, model, w;
    int base, n;
    void'($urandom(32'h00C0FFEE));
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(8'h00, m);
    check("R1 mode after reset", m, 32'h0000_0040);
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 request after reset", 32'(mem_req), 0);

    // directed set / clear and read-only bits
    wr(8'h00, 32'h0000_1180);
    rd(8'h00, m);
    check("R2 set alias", m, 32'h0000_11C0);
    wr(8'h00, 32'h0000_0050);
    rd(8'h00, m);
    check("R4 halt/active ignore set", m, 32'h0000_11C0);
    wr(8'h04, 32'h0000_1050);
    rd(8'h00, m);
    check("R3 clear alias", m, 32'h0000_01C0);

    // random set/clear with run held low
    model = 32'h0000_0180;
    for (int i = 0; i < 24; i++) begin
      w = $urandom & ~32'h0000_0008;
      if ($urandom % 2) begin
        wr(8'h00, w); model = model | (w & WMASK);
        rd(8'h00, m); check("R2 random set", m, model | 32'h40);
      end else begin
        wr(8'h04, w); model = model & ~(w & WMASK);
        rd(8'h00, m); check("R3 random clear", m, model | 32'h40);
      end
    end
    wr(8'h04, 32'hFFFF_FFFF);

    // descriptor read-back
    for (int i = 0; i < 5; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h08 : (i == 1) ? 8'h0C : (i == 2) ? 8'h10 : (i == 3) ? 8'h14 : 8'h18;
      w = $urandom;
      wr(a, w);
      rd(a, d);
      check("R4 descriptor read-back", d, (a == 8'h10 || a == 8'h18) ? (w & 32'h000F_FFFF) : w);
    end

    // buffer 0, memory to FIFO, 32-bit, upper address bits 2
    wr(8'h08, 32'h9000_0040);
    wr(8'h0C, 32'h0000_1000);
    wr(8'h10, 32'h0002_0003);
    log_n = 0; base = irq_cnt;
    wr(8'h00, 32'h0000_0109);
    wait_irq(base + 1);
    wait_halt();
    check("R5 access count", log_n, 6);
    for (int i = 0; i < 3; i++) begin
      check("R5 read from buffer", log_addr[2*i], 32'h2000_1000 + 4*i);
      check("R5 read flag", 32'(log_we[2*i]), 0);
      check("R5 write to FIFO", log_addr[2*i+1], 32'h9000_0040);
      check("R5 moved data", log_data[2*i+1], mem_val(32'h2000_1000 + 4*i));
    end
    rd(8'h00, m);
    check("R6 R7 mode after buffer done", m, 32'h0000_015A);
    check("R6 one interrupt", irq_cnt - base, 1);
    rd(8'h10, d);
    check("R11 count exhausted", d, 32'h0002_0000);
    rd(8'h0C, d);
    check("R5 start advanced", d, 32'h0000_100C);
    repeat (20) @(negedge clk);
    check("R7 stalled, no requests", log_n, 6);

    // clear done 0
    wr(8'h04, 32'h0000_0002);
    rd(8'h00, m);
    check("R10 done cleared", m, 32'h0000_0158);

    // ping-pong, FIFO to memory, 16-bit
    wr(8'h04, 32'h0000_0180);
    wr(8'h00, 32'h0000_1080);
    wr(8'h14, 32'h0000_3000);
    wr(8'h18, 32'h0000_0002);
    wr(8'h0C, 32'h0000_4000);
    wr(8'h10, 32'h0000_0002);
    log_n = 0; base = irq_cnt;
    wr(8'h00, 32'h0000_0005);
    wait_irq(base + 2);
    wait_halt();
    check("R7 ping-pong access count", log_n, 8);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ba;
      ba = (k < 2) ? 32'h3000 + 2*k : 32'h4000 + 2*(k-2);
      check("R5 dir1 read FIFO", log_addr[2*k], 32'h9000_0040);
      check("R5 dir1 write buffer", log_addr[2*k+1], ba);
      check("R5 dir1 data", log_data[2*k+1], mem_val(32'h9000_0040));
    end
    rd(8'h00, m);
    check("R7 mode after both buffers", m, 32'h0000_10FA);
    check("R6 two interrupts", irq_cnt - base, 2);

    // byte order, 32-bit, buffer 1
    wr(8'h04, 32'h0000_11A2);
    wr(8'h00, 32'h0000_2100);
    wr(8'h14, 32'h0000_5000);
    wr(8'h18, 32'h0000_0001);
    log_n = 0; base = irq_cnt;
    wr(8'h00, 32'h0000_0004);
    wait_irq(base + 1);
    wait_halt();
    check("R12 32-bit access count", log_n, 2);
    check("R12 32-bit reversed", log_data[1], bswap(mem_val(32'h0000_5000)));

    // byte order, 16-bit, buffer 0
    wr(8'h04, 32'h0000_01A0);
    wr(8'h00, 32'h0000_0080);
    wr(8'h0C, 32'h0000_6000);
    wr(8'h10, 32'h0000_0001);
    log_n = 0; base = irq_cnt;
    wr(8'h00, 32'h0000_0001);
    wait_irq(base + 1);
    wait_halt();
    d = mem_val(32'h0000_6000);
    check("R12 16-bit swapped", log_data[1], {16'h0000, d[7:0], d[15:8]});

    // stop mid-buffer and resume, 8-bit, buffer 1
    wr(8'h04, 32'h0000_21A2);
    wr(8'h14, 32'h0000_7000);
    wr(8'h18, 32'h0000_0028);
    log_n = 0; base = irq_cnt;
    wr(8'h00, 32'h0000_0004);
    wait_log(10);
    wr(8'h04, 32'h0000_0008);
    wait_halt();
    n = log_n;
    check("R8 beat finished before halt", n % 2, 0);
    repeat (20) @(negedge clk);
    check("R8 no requests after halt", log_n, n);
    check("R8 no interrupt on stop", irq_cnt - base, 0);
    rd(8'h18, d);
    check("R11 residue after stop", d, 40 - n/2);
    for (int i = 0; i < n/2; i++)
      check("R5 byte stride", log_addr[2*i], 32'h7000 + i);
    wr(8'h00, 32'h0000_0008);
    rd(8'h00, m);
    check("R9 halt drops on resume", 32'(m[6]), 0);
    wait_irq(base + 1);
    wait_halt();
    check("R9 full transfer after resume", log_n, 80);
    rd(8'h18, d);
    check("R9 count exhausted", d, 0);

    // constrained random transfers
    for (int it = 0; it < 8; it++) begin
      int wsel, dsel, cnt, ab;
      logic [31:0] st, fa, hi, ba;
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h00, m);
      ab   = m[4];
      wsel = $urandom % 3;
      dsel = $urandom % 2;
      cnt  = 1 + $urandom % 4;
      st   = $urandom & 32'h0FFF_FFFC;
      hi   = $urandom % 16;
      fa   = $urandom;
      wr(8'h08, fa);
      wr(ab ? 8'h14 : 8'h0C, st);
      wr(ab ? 8'h18 : 8'h10, (hi << 16) | cnt);
      log_n = 0; base = irq_cnt;
      wr(8'h00, 32'h8 | (ab ? 32'h4 : 32'h1) | (wsel << 7) | (dsel << 12));
      wait_irq(base + 1);
      wait_halt();
      check("R5 random access count", log_n, 2*cnt);
      for (int i = 0; i < cnt; i++) begin
        ba = (hi << 28) | ((st + i*step_of(wsel)) & 32'h0FFF_FFFF);
        check("R5 random source", log_addr[2*i], dsel ? fa : ba);
        check("R5 random destination", log_addr[2*i+1], dsel ? ba : fa);
        check("R5 random data", log_data[2*i+1], mem_val(dsel ? fa : ba));
      end
      rd(8'h00, m);
      check("R6 random active switched", 32'(m[4]), 32'(ab == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule